// File: doc/BRIEF.md
# Egress DSCP Rewrite Selector

This block decides which DSCP value goes back into each frame as it leaves the switch. It holds a small classification table that turns a frame's QoS class and drop-precedence level into a classified DSCP, plus a per-egress-port configuration word. Each lookup supplies an already-extracted frame descriptor: egress port, QoS class, DP level and the DSCP carried in the frame. The block returns, one cycle later, the DSCP to write into the frame.

The classified value is used only when the egress port trusts DSCP and has at least one rewrite mapping turned on. In every other case the frame's own DSCP passes through unchanged. Software fills the table and the port words through a plain register write and read port. The read port is combinational.

Top module: `dscp_rew`

## Requirements
- R1: After reset, `outValid` is 0. Every table entry reads as 0. Every port word reads as 0x100, which means trust is set and both mapping enables are clear.
- R2: With `regSel`=0, `regAddr` selects a table entry. A write stores `regWrData[9:4]` as that entry's DSCP. A read returns the DSCP in bits 9:4 and zero in every other bit.
- R3: With `regSel`=1, `regAddr` selects an egress port. In the port word, bit 0 is remap-enable, bit 1 is update-enable and bit 8 is trust. A write stores those three bits only, and a read returns zero in every other bit.
- R4: A table access with `regAddr` of 32 or more is out of range, and so is a port access with `regAddr` of 70 or more. An out-of-range write changes no stored state, including the entry whose low address bits it shares. An out-of-range read returns 0.
- R5: The classified DSCP is the table entry at index 8*`inDp` + `inQos`.
- R6: For an in-range port, `outDscp` is the classified DSCP when the port's trust bit is set and at least one of its update-enable and remap-enable bits is set. Otherwise `outDscp` equals `inDscp`.
- R7: `outValid` rises in the cycle after a cycle with `inValid` high. It is low in the cycle after a cycle with `inValid` low.
- R8: A lookup in the same cycle as a write to the entry it reads returns the value held before the write. The next lookup returns the new value.
- R9: A lookup whose `inPort` is 70 or more always returns `inDscp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the table, 1 selects the port words |
| regAddr | input | 7 | Table index or port number |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regSel` and `regAddr` |
| inValid | input | 1 | Lookup request valid |
| inPort | input | 7 | Egress port of the frame |
| inQos | input | 3 | QoS class of the frame |
| inDp | input | 2 | Drop-precedence level |
| inDscp | input | 6 | DSCP carried in the frame |
| outValid | output | 1 | Lookup result valid |
| outDscp | output | 6 | DSCP to write into the frame |

## Verification
A lookup result appears on `outValid` and `outDscp` one clock after the edge that accepts the request. The bench therefore drives each request on a falling edge and compares the result on the next falling edge, half a cycle after the result register loads. Register reads are combinational, so a read is checked a short delay after the address is driven, with no clock edge in between. Register writes take effect at the next rising edge, and the same-cycle case of R8 is checked by overlapping a write and a lookup of one entry within a single clock.

// File: rtl/dscp_rew_pkg.sv
package dscp_rew_pkg;
  localparam int DSCP_W    = 6;
  localparam int QOS_W     = 3;
  localparam int DP_W      = 2;
  localparam int NUM_PORTS = 70;
  localparam int TBL_IDX_W = QOS_W + DP_W;
  localparam int TBL_DEPTH = 1 << TBL_IDX_W;
  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int ADDR_W    = (PORT_W > TBL_IDX_W) ? PORT_W : TBL_IDX_W;
  localparam int WORD_W    = 32;
  localparam int TBL_LSB   = 4;
  localparam int REMAP_BIT = 0;
  localparam int UPD_BIT   = 1;
  localparam int TRUST_BIT = 8;

  typedef struct packed {
    logic tblWe;
    logic portWe;
    logic rdTblHit;
    logic rdPortHit;
    logic [TBL_IDX_W-1:0] tblIdx;
    logic [PORT_W-1:0] portIdx;
    logic [DSCP_W-1:0] dscpVal;
    logic trustVal;
    logic updVal;
    logic remapVal;
  } ctrlStrobes_t;
endpackage

// File: rtl/dscp_rew_ctrl.sv
module dscp_rew_ctrl
  import dscp_rew_pkg::*;
(
  input  logic regWe,
  input  logic regSel,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output ctrlStrobes_t strb
);
  logic tblHit;
  logic portHit;

  assign tblHit  = regAddr < ADDR_W'(TBL_DEPTH);
  assign portHit = regAddr < ADDR_W'(NUM_PORTS);

  always_comb begin
    strb = '0;
    strb.tblWe     = regWe & ~regSel & tblHit;
    strb.portWe    = regWe & regSel & portHit;
    strb.rdTblHit  = ~regSel & tblHit;
    strb.rdPortHit = regSel & portHit;
    strb.tblIdx    = regAddr[TBL_IDX_W-1:0];
    strb.portIdx   = regAddr[PORT_W-1:0];
    strb.dscpVal   = regWrData[TBL_LSB +: DSCP_W];
    strb.trustVal  = regWrData[TRUST_BIT];
    strb.updVal    = regWrData[UPD_BIT];
    strb.remapVal  = regWrData[REMAP_BIT];
  end
endmodule

// File: rtl/dscp_rew_dp.sv
module dscp_rew_dp
  import dscp_rew_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobes_t strb,
  input  logic inValid,
  input  logic [PORT_W-1:0] inPort,
  input  logic [QOS_W-1:0] inQos,
  input  logic [DP_W-1:0] inDp,
  input  logic [DSCP_W-1:0] inDscp,
  output logic outValid,
  output logic [DSCP_W-1:0] outDscp,
  output logic [WORD_W-1:0] rdData
);
  logic [DSCP_W-1:0] tblMem [TBL_DEPTH];
  logic [NUM_PORTS-1:0] trustQ;
  logic [NUM_PORTS-1:0] updQ;
  logic [NUM_PORTS-1:0] remapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_DEPTH; i++) tblMem[i] <= '0;
    end else if (strb.tblWe) begin
      tblMem[strb.tblIdx] <= strb.dscpVal;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        trustQ[p] <= 1'b1;
        updQ[p]   <= 1'b0;
        remapQ[p] <= 1'b0;
      end else if (strb.portWe && strb.portIdx == PORT_W'(p)) begin
        trustQ[p] <= strb.trustVal;
        updQ[p]   <= strb.updVal;
        remapQ[p] <= strb.remapVal;
      end
    end
  end

  logic portOk;
  logic [PORT_W-1:0] portSafe;
  logic [TBL_IDX_W-1:0] lkIdx;
  logic useClass;
  logic [DSCP_W-1:0] nextDscp;

  assign portOk   = inPort < PORT_W'(NUM_PORTS);
  assign portSafe = portOk ? inPort : '0;
  assign lkIdx    = {inDp, inQos};
  assign useClass = portOk & trustQ[portSafe] & (updQ[portSafe] | remapQ[portSafe]);
  assign nextDscp = useClass ? tblMem[lkIdx] : inDscp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outDscp  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) outDscp <= nextDscp;
    end
  end

  logic [PORT_W-1:0] rdPortSafe;
  assign rdPortSafe = strb.rdPortHit ? strb.portIdx : '0;

  always_comb begin
    rdData = '0;
    if (strb.rdTblHit) rdData[TBL_LSB +: DSCP_W] = tblMem[strb.tblIdx];
    if (strb.rdPortHit) begin
      rdData[TRUST_BIT] = trustQ[rdPortSafe];
      rdData[UPD_BIT]   = updQ[rdPortSafe];
      rdData[REMAP_BIT] = remapQ[rdPortSafe];
    end
  end
endmodule

// File: rtl/dscp_rew.sv
module dscp_rew
  import dscp_rew_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic regWe,
  input  logic regSel,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic inValid,
  input  logic [PORT_W-1:0] inPort,
  input  logic [QOS_W-1:0] inQos,
  input  logic [DP_W-1:0] inDp,
  input  logic [DSCP_W-1:0] inDscp,
  output logic outValid,
  output logic [DSCP_W-1:0] outDscp
);
  ctrlStrobes_t strb;

  dscp_rew_ctrl u_ctrl (
    .regWe(regWe), .regSel(regSel), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb)
  );

  dscp_rew_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inValid(inValid), .inPort(inPort), .inQos(inQos), .inDp(inDp),
    .inDscp(inDscp), .outValid(outValid), .outDscp(outDscp),
    .rdData(regRdData)
  );
endmodule

// File: rtl/dscp_rew_chk.sv
module dscp_rew_chk
  import dscp_rew_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic regSel,
  input logic [ADDR_W-1:0] regAddr,
  input logic [WORD_W-1:0] regRdData,
  input logic inValid,
  input logic [PORT_W-1:0] inPort,
  input logic [DSCP_W-1:0] inDscp,
  input logic outValid,
  input logic [DSCP_W-1:0] outDscp
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r9_oor_port_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inPort >= PORT_W'(NUM_PORTS)) |=> (outDscp == $past(inDscp)));

  a_r4_oor_tbl_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!regSel && regAddr >= ADDR_W'(TBL_DEPTH)) |-> (regRdData == '0));

  a_r4_oor_port_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regAddr >= ADDR_W'(NUM_PORTS)) |-> (regRdData == '0));

  a_r2_tbl_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (regRdData[WORD_W-1:TBL_LSB+DSCP_W] == '0 && regRdData[TBL_LSB-1:0] == '0));

  a_r3_port_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> ((regRdData & ~((WORD_W'(1) << TRUST_BIT) | (WORD_W'(1) << UPD_BIT)
                 | (WORD_W'(1) << REMAP_BIT))) == '0));
endmodule

bind dscp_rew dscp_rew_chk u_chk (.*);

// File: tb/dscp_rew_tb.sv
module dscp_rew_tb;
  localparam time CYC = 20ns;
  localparam int NV = 10;
  // {port[6:0], dp[1:0], qos[2:0], frameDscp[5:0], expected[5:0]}
  localparam logic [23:0] VEC [NV] = '{
    {7'd0,   2'd0, 3'd0, 6'd5,  6'd10},
    {7'd0,   2'd1, 3'd3, 6'd5,  6'd21},
    {7'd1,   2'd3, 3'd7, 6'd63, 6'd41},
    {7'd2,   2'd2, 3'd1, 6'd7,  6'd7},
    {7'd3,   2'd1, 3'd1, 6'd9,  6'd9},
    {7'd69,  2'd2, 3'd5, 6'd0,  6'd31},
    {7'd70,  2'd0, 3'd0, 6'd12, 6'd12},
    {7'd127, 2'd3, 3'd7, 6'd33, 6'd33},
    {7'd5,   2'd0, 3'd2, 6'd44, 6'd44},
    {7'd1,   2'd0, 3'd7, 6'd1,  6'd17}
  };

  logic clk = 0, rstN = 0;
  logic regWe = 0, regSel = 0;
  logic [6:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic inValid = 0;
  logic [6:0] inPort = 0;
  logic [2:0] inQos = 0;
  logic [1:0] inDp = 0;
  logic [5:0] inDscp = 0;
  logic outValid;
  logic [5:0] outDscp;
  int nChk = 0, nFail = 0;

  always #(CYC/2) clk = ~clk;

  dscp_rew u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regAddr = a; regWrData = d; regWe = 1;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rd(input string req, input logic sel, input logic [6:0] a, input logic [31:0] exp);
    regSel = sel; regAddr = a;
    #1;
    chk(req, regRdData, exp);
  endtask

  task automatic look(input string req, input logic [6:0] p, input logic [1:0] dp,
                      input logic [2:0] q, input logic [5:0] fd, input logic [5:0] exp);
    @(negedge clk);
    inPort = p; inDp = dp; inQos = q; inDscp = fd; inValid = 1;
    @(negedge clk);
    inValid = 0;
    chk({req, " valid"}, 32'(outValid), 32'd1);
    chk(req, 32'(outDscp), 32'(exp));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(CYC * 100000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    #(CYC * 3);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 outValid", 32'(outValid), 32'd0);
    rd("R1 table", 0, 7'd3, 32'h0);
    rd("R1 port", 1, 7'd10, 32'h100);
    // R2 only bits 9:4 kept
    wr(0, 7'd12, 32'hFFFF_FFFF);
    rd("R2 table field", 0, 7'd12, 32'h3F0);
    // R3 port bits 0,1,8
    wr(1, 7'd4, 32'hFFFF_FFFF);
    rd("R3 port field", 1, 7'd4, 32'h103);
    wr(1, 7'd4, 32'h0000_0002);
    rd("R3 port update only", 1, 7'd4, 32'h002);
    // R4 out-of-range writes
    wr(0, 7'd8, 32'h0000_0150);
    wr(0, 7'd40, 32'h0000_03F0);
    rd("R4 alias table entry", 0, 7'd8, 32'h150);
    rd("R4 oor table read", 0, 7'd40, 32'h0);
    wr(1, 7'd70, 32'h0000_0003);
    rd("R4 oor port read", 1, 7'd70, 32'h0);
    rd("R4 alias port", 1, 7'd6, 32'h100);
    // program table: entry i = i + 10
    for (int i = 0; i < 32; i++) wr(0, 7'(i), 32'(i + 10) << 4);
    wr(1, 7'd0, 32'h101);
    wr(1, 7'd1, 32'h102);
    wr(1, 7'd2, 32'h002);
    wr(1, 7'd3, 32'h100);
    wr(1, 7'd69, 32'h103);
    // R5 R6 R9 vector table
    for (int v = 0; v < NV; v++) begin
      look("R5 R6 R9 vector", VEC[v][23:17], VEC[v][16:15], VEC[v][14:12],
           VEC[v][11:6], VEC[v][5:0]);
    end
    // R7 idle cycle
    @(negedge clk);
    chk("R7 idle", 32'(outValid), 32'd0);
    // R8 same-cycle write and lookup
    @(negedge clk);
    inPort = 7'd0; inDp = 2'd0; inQos = 3'd0; inDscp = 6'd2; inValid = 1;
    regSel = 0; regAddr = 7'd0; regWrData = 32'd50 << 4; regWe = 1;
    @(negedge clk);
    regWe = 0; inValid = 0;
    chk("R8 old value", 32'(outDscp), 32'd10);
    look("R8 new value", 7'd0, 2'd0, 3'd0, 6'd2, 6'd50);
    // R6 trust cleared disables rewrite
    wr(1, 7'd0, 32'h003);
    look("R6 untrusted", 7'd0, 2'd1, 3'd3, 6'd60, 6'd60);
    finishRun();
  end
endmodule